// File: doc/BRIEF.md
# Secure Control Register Bank with Atomic Bit Aliases

This block holds a bank of 32-bit control registers and serves requests from two masters on a shared request port pair. A request carries a byte address, an operation code, write data, a mask and a flag that marks the requester as trusted. Any requester may read. Only a trusted requester may change a register. An untrusted write, or any bad request, gets an error response and changes nothing. The contents of every register are driven out of the block as flat vectors.

Registers sit in two pages. Page 0 is the shared "alive" page, where the register index is the word offset `addr[13:2]`. Two masters can each flip a single bit there without losing the other's update, because writes to aliased addresses set or clear one bit in one step. Page 1 starts at byte address 0x10000 and uses the word offset `addr[15:2]`. There a masked read-modify-write is done as one operation. `addr[1:0]` are ignored.

Each request port uses valid/ready. Port 0 is always ready. Port 1 is ready only in cycles where port 0 is not presenting a request. A request is accepted in the cycle where valid and ready are both high. Every accepted request gets exactly one response one cycle later. The response carries the port number. Responses cannot be stalled, so a consumer must take `rsp_valid` whenever it is high.

Top module: `sec_regbank`

## Requirements
- R1: After reset every register reads as zero, `alive_regs`/`upper_regs` are all zero and `rsp_valid` is low.
- R2: `req_ready[0]` is always high. `req_ready[1]` is high only when `req_valid[0]` is low. An accepted request is answered one cycle later with `rsp_valid` high and `rsp_port` set to its port. Responses come back in acceptance order.
- R3: A trusted write (op 1) replaces the whole word. Page 0 register i lives at byte address 4*i, with address bits 15:14 zero. Page 1 register i lives at 0x10000 + 4*i.
- R4: A trusted op-1 write to page 0 with address bits 15:14 = 2'b11 sets only bit `wdata[4:0]` of the register at `addr[13:2]`. Bits 31:5 of `wdata` are ignored, and all other register bits keep their values.
- R5: A trusted op-1 write to page 0 with address bits 15:14 = 2'b10 clears only bit `wdata[4:0]` of that register.
- R6: On page 0, address bits 15:14 = 2'b01 give a plain full-word write to the register at `addr[13:2]`. A read (op 0) through any alias value returns the plain register contents.
- R7: Op 2 on page 1 from a trusted requester stores `(old & ~mask) | (wdata & mask)`. Op 2 on page 0 is refused with an error and changes nothing.
- R8: A write (op 1 or op 2) from an untrusted requester (`req_secure` = 0) returns `rsp_err` = 1 and leaves every register unchanged. A permitted write returns `rsp_err` = 0.
- R9: A read (op 0) of a mapped register from either kind of requester returns `rsp_err` = 0 and the register value. Write responses carry `rsp_rdata` = 0.
- R10: An address past the implemented registers of either page, an address on any other page, or op 3 returns `rsp_err` = 1 and `rsp_rdata` = 0, with no register change.
- R11: Single-bit alias updates to the same register from both ports, issued together, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_PORTS | Request present, per port |
| req_ready | output | NUM_PORTS | Request may be accepted, per port |
| req_addr | input | NUM_PORTS x ADDR_W | Byte address, per port |
| req_op | input | NUM_PORTS x 2 | 0 read, 1 write, 2 masked update, 3 reserved |
| req_wdata | input | NUM_PORTS x 32 | Write data or bit index |
| req_mask | input | NUM_PORTS x 32 | Mask for masked update |
| req_secure | input | NUM_PORTS | Requester is trusted |
| rsp_valid | output | 1 | Response present |
| rsp_port | output | PORT_W | Port the response belongs to |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data |
| alive_regs | output | NUM_ALIVE x 32 | Page 0 register contents |
| upper_regs | output | NUM_UPPER x 32 | Page 1 register contents |

## Verification
The assertions check several rules on every cycle:
- at most one grant is given, port 0 has priority, and a response follows each acceptance;
- an untrusted write never changes any register;
- a read never changes any register;
- an alias write changes at most one bit of the whole bank;
- unmapped addresses and masked updates on page 0 report an error.

The exact values need the bench's scenarios. These include the new word after a set, clear or masked update, the ignoring of the high bits of the bit index, and the read-back through aliases. They also include two ports updating the same register one after the other.

// File: rtl/sregs_pkg.sv
package sregs_pkg;
  localparam int WORD_W    = 32;
  localparam int BIT_IDX_W = 5;
  localparam int OFF_W     = 14;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_MASKED = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    UPD_WORD,
    UPD_SET,
    UPD_CLR,
    UPD_MASKED
  } upd_e;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_ALIVE,
    RGN_UPPER
  } rgn_e;
endpackage

// File: rtl/sregs_arb.sv
module sregs_arb #(
  parameter int NUM_PORTS = 2,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] valid,
  output logic [NUM_PORTS-1:0] ready,
  output logic [NUM_PORTS-1:0] gnt,
  output logic [PW-1:0]        gnt_idx,
  output logic                 any_gnt
);
  logic taken;

  // lowest index wins; a port is ready when no lower port is asking
  always_comb begin
    taken   = 1'b0;
    gnt_idx = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      ready[p] = !taken;
      if (valid[p] && !taken) gnt_idx = PW'(p);
      if (valid[p]) taken = 1'b1;
    end
  end

  assign gnt     = valid & ready;
  assign any_gnt = |valid;

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_port0_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready[0]);
  for (genvar p = 1; p < NUM_PORTS; p++) begin : g_prio
    assert_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready[p] |-> !valid[0]);
  end
endmodule

// File: rtl/sregs_dec.sv
module sregs_dec
  import sregs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_ALIVE = 8,
  parameter int NUM_UPPER = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [OFF_W-1:0]  idx,
  output logic              alias_set,
  output logic              alias_clr
);
  localparam int PAGE_W = ADDR_W - 16;

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  alive_off;
  logic [OFF_W-1:0]  upper_off;
  logic              unused_lsb;

  assign page       = addr[ADDR_W-1:16];
  assign alive_off  = {2'b00, addr[13:2]};
  assign upper_off  = addr[15:2];
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    rgn = RGN_NONE;
    idx = '0;
    if (page == PAGE_W'(0)) begin
      idx = alive_off;
      if (int'(alive_off) < NUM_ALIVE) rgn = RGN_ALIVE;
    end else if (page == PAGE_W'(1)) begin
      idx = upper_off;
      if (int'(upper_off) < NUM_UPPER) rgn = RGN_UPPER;
    end
  end

  assign alias_set = (rgn == RGN_ALIVE) && (addr[15:14] == 2'b11);
  assign alias_clr = (rgn == RGN_ALIVE) && (addr[15:14] == 2'b10);
endmodule

// File: rtl/sregs_store.sv
module sregs_store
  import sregs_pkg::*;
#(
  parameter int NUM_ALIVE = 8,
  parameter int NUM_UPPER = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  rgn_e                        rgn,
  input  logic [OFF_W-1:0]            idx,
  input  upd_e                        upd,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [WORD_W-1:0]           mask,
  output logic [WORD_W-1:0]           rd_data,
  output logic [NUM_ALIVE*WORD_W-1:0] alive_flat,
  output logic [NUM_UPPER*WORD_W-1:0] upper_flat
);
  logic [WORD_W-1:0] alive_q [NUM_ALIVE];
  logic [WORD_W-1:0] upper_q [NUM_UPPER];

  function automatic logic [WORD_W-1:0] next_word(
    input logic [WORD_W-1:0] old, input upd_e kind,
    input logic [WORD_W-1:0] d, input logic [WORD_W-1:0] m);
    logic [WORD_W-1:0] onehot;
    onehot = WORD_W'(1) << d[BIT_IDX_W-1:0];
    case (kind)
      UPD_SET:    return old | onehot;
      UPD_CLR:    return old & ~onehot;
      UPD_MASKED: return (old & ~m) | (d & m);
      default:    return d;
    endcase
  endfunction

  for (genvar i = 0; i < NUM_ALIVE; i++) begin : g_alive
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alive_q[i] <= '0;
      else if (we && rgn == RGN_ALIVE && idx == OFF_W'(i))
        alive_q[i] <= next_word(alive_q[i], upd, wdata, mask);
    end
    assign alive_flat[i*WORD_W +: WORD_W] = alive_q[i];
  end

  for (genvar i = 0; i < NUM_UPPER; i++) begin : g_upper
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upper_q[i] <= '0;
      else if (we && rgn == RGN_UPPER && idx == OFF_W'(i))
        upper_q[i] <= next_word(upper_q[i], upd, wdata, mask);
    end
    assign upper_flat[i*WORD_W +: WORD_W] = upper_q[i];
  end

  always_comb begin
    rd_data = '0;
    if (rgn == RGN_ALIVE) begin
      for (int i = 0; i < NUM_ALIVE; i++)
        if (idx == OFF_W'(i)) rd_data = alive_q[i];
    end else if (rgn == RGN_UPPER) begin
      for (int i = 0; i < NUM_UPPER; i++)
        if (idx == OFF_W'(i)) rd_data = upper_q[i];
    end
  end

  logic [(NUM_ALIVE+NUM_UPPER)*WORD_W-1:0] bank;
  assign bank = {upper_flat, alive_flat};

  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (upd == UPD_SET || upd == UPD_CLR)) |=> $countones(bank ^ $past(bank)) <= 1);
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bank));
endmodule

// File: rtl/sec_regbank.sv
module sec_regbank
  import sregs_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 20,
  parameter int NUM_ALIVE = 8,
  parameter int NUM_UPPER = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_PORTS-1:0]                   req_valid,
  output logic [NUM_PORTS-1:0]                   req_ready,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]       req_addr,
  input  logic [NUM_PORTS-1:0][1:0]              req_op,
  input  logic [NUM_PORTS-1:0][31:0]             req_wdata,
  input  logic [NUM_PORTS-1:0][31:0]             req_mask,
  input  logic [NUM_PORTS-1:0]                   req_secure,
  output logic                                   rsp_valid,
  output logic [PORT_W-1:0]                      rsp_port,
  output logic                                   rsp_err,
  output logic [31:0]                            rsp_rdata,
  output logic [NUM_ALIVE*32-1:0]                alive_regs,
  output logic [NUM_UPPER*32-1:0]                upper_regs
);
  logic [NUM_PORTS-1:0] gnt;
  logic [PORT_W-1:0]    gnt_idx;
  logic                 any_gnt;

  sregs_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .ready(req_ready),
    .gnt(gnt), .gnt_idx(gnt_idx), .any_gnt(any_gnt));

  logic [ADDR_W-1:0] sel_addr;
  op_e               sel_op;
  logic [31:0]       sel_wdata, sel_mask;
  logic              sel_sec;

  assign sel_addr  = req_addr[gnt_idx];
  assign sel_op    = op_e'(req_op[gnt_idx]);
  assign sel_wdata = req_wdata[gnt_idx];
  assign sel_mask  = req_mask[gnt_idx];
  assign sel_sec   = req_secure[gnt_idx];

  rgn_e             rgn;
  logic [OFF_W-1:0] idx;
  logic             alias_set, alias_clr;

  sregs_dec #(.ADDR_W(ADDR_W), .NUM_ALIVE(NUM_ALIVE), .NUM_UPPER(NUM_UPPER)) u_dec (
    .addr(sel_addr), .rgn(rgn), .idx(idx),
    .alias_set(alias_set), .alias_clr(alias_clr));

  logic is_wr, refuse, we;
  upd_e upd;

  assign is_wr  = (sel_op != OP_READ);
  assign refuse = (rgn == RGN_NONE) || (sel_op == OP_RSVD) ||
                  (is_wr && !sel_sec) ||
                  (sel_op == OP_MASKED && rgn == RGN_ALIVE);
  assign we     = any_gnt && is_wr && !refuse;

  always_comb begin
    if (sel_op == OP_MASKED) upd = UPD_MASKED;
    else if (alias_set)      upd = UPD_SET;
    else if (alias_clr)      upd = UPD_CLR;
    else                     upd = UPD_WORD;
  end

  logic [31:0] rd_data;

  sregs_store #(.NUM_ALIVE(NUM_ALIVE), .NUM_UPPER(NUM_UPPER)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .rgn(rgn), .idx(idx), .upd(upd),
    .wdata(sel_wdata), .mask(sel_mask), .rd_data(rd_data),
    .alive_flat(alive_regs), .upper_flat(upper_regs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= '0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= any_gnt;
      rsp_port  <= gnt_idx;
      rsp_err   <= any_gnt && refuse;
      rsp_rdata <= (any_gnt && sel_op == OP_READ && !refuse) ? rd_data : '0;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_gnt |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_gnt |=> !rsp_valid);
  assert_untrusted_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && is_wr && !sel_sec) |=>
      (rsp_err && $stable(alive_regs) && $stable(upper_regs)));
  assert_read_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && sel_op == OP_READ && rgn != RGN_NONE) |=>
      (!rsp_err && $stable(alive_regs) && $stable(upper_regs)));
  assert_masked_alive_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && sel_op == OP_MASKED && rgn == RGN_ALIVE) |=>
      (rsp_err && $stable(alive_regs)));
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && rgn == RGN_NONE) |=> (rsp_err && rsp_rdata == 32'd0));
endmodule

// File: tb/sec_regbank_test.sv
module sec_regbank_test;
  localparam int NA = 8;
  localparam int NU = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        req_valid = '0;
  logic [1:0]        req_ready;
  logic [1:0][19:0]  req_addr = '0;
  logic [1:0][1:0]   req_op = '0;
  logic [1:0][31:0]  req_wdata = '0;
  logic [1:0][31:0]  req_mask = '0;
  logic [1:0]        req_secure = '0;
  logic              rsp_valid;
  logic [0:0]        rsp_port;
  logic              rsp_err;
  logic [31:0]       rsp_rdata;
  logic [NA*32-1:0]  alive_regs;
  logic [NU*32-1:0]  upper_regs;

  sec_regbank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata),
    .req_mask(req_mask), .req_secure(req_secure), .rsp_valid(rsp_valid),
    .rsp_port(rsp_port), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .alive_regs(alive_regs), .upper_regs(upper_regs));

  always #5 clk = ~clk;

  typedef struct {
    int          port;
    logic        err;
    logic [31:0] rdata;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [31:0] m_alive [NA];
  logic [31:0] m_upper [NU];

  // reference model of one accepted request, built from the requirements
  task automatic expect_req(input int p, input logic [19:0] a, input logic [1:0] op,
                            input logic [31:0] wd, input logic [31:0] mk,
                            input logic sec, input string tag);
    exp_t e;
    int   idx;
    bit   alive, mapped, err;
    logic [31:0] cur;
    alive = 0; mapped = 0; idx = 0; cur = '0;
    if (a[19:16] == 4'd0) begin
      idx = int'(a[13:2]); alive = 1; mapped = (idx < NA);
    end else if (a[19:16] == 4'd1) begin
      idx = int'(a[15:2]); mapped = (idx < NU);
    end
    if (mapped) cur = alive ? m_alive[idx] : m_upper[idx];
    err = !mapped || op == 2'd3 || (op != 2'd0 && !sec) || (op == 2'd2 && alive);
    e.port = p; e.err = err; e.tag = tag;
    e.rdata = (op == 2'd0 && !err) ? cur : 32'd0;
    sb.push_back(e);
    if (op != 2'd0 && !err) begin
      logic [31:0] nw;
      if (op == 2'd2) nw = (cur & ~mk) | (wd & mk);
      else if (alive && a[15:14] == 2'b11) nw = cur | (32'd1 << wd[4:0]);
      else if (alive && a[15:14] == 2'b10) nw = cur & ~(32'd1 << wd[4:0]);
      else nw = wd;
      if (alive) m_alive[idx] = nw; else m_upper[idx] = nw;
    end
  endtask

  task automatic issue(input int p, input logic [19:0] a, input logic [1:0] op,
                       input logic [31:0] wd, input logic [31:0] mk,
                       input logic sec, input string tag);
    req_addr[p] = a; req_op[p] = op; req_wdata[p] = wd;
    req_mask[p] = mk; req_secure[p] = sec; req_valid[p] = 1'b1;
    #1;
    while (!req_ready[p]) begin
      @(negedge clk); #1;
    end
    expect_req(p, a, op, wd, mk, sec, tag);
    @(negedge clk);
    req_valid[p] = 1'b0;
  endtask

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: pop and compare every response away from the clock edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(0, "R2 unexpected response", {31'd0, rsp_valid}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_port == e.port[0], {e.tag, " port"}, {31'd0, rsp_port}, e.port);
        check(rsp_err == e.err && rsp_rdata == e.rdata, e.tag,
              {rsp_err, rsp_rdata[30:0]}, {e.err, e.rdata[30:0]});
        if (rsp_rdata != e.rdata)
          check(0, {e.tag, " rdata"}, rsp_rdata, e.rdata);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NA; i++) m_alive[i] = '0;
    for (int i = 0; i < NU; i++) m_upper[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(alive_regs == '0, "R1 alive bank after reset", alive_regs[31:0], 32'd0);
    check(upper_regs == '0, "R1 upper bank after reset", upper_regs[31:0], 32'd0);
    check(rsp_valid == 1'b0, "R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
    issue(0, 20'h00004, 2'd0, 0, 0, 0, "R1 read zero");

    issue(0, 20'h00008, 2'd1, 32'hA5A5_0F0F, 0, 1, "R3 word write page0");
    issue(1, 20'h10004, 2'd1, 32'h1234_5678, 0, 1, "R3 word write page1");
    issue(1, 20'h00008, 2'd0, 0, 0, 0, "R9 untrusted read page0");
    issue(0, 20'h10004, 2'd0, 0, 0, 1, "R9 trusted read page1");

    issue(0, 20'h0C008, 2'd1, 32'hFFFF_FFE4, 0, 1, "R4 set bit 4 high bits junk");
    issue(0, 20'h0C008, 2'd1, 32'h0000_001F, 0, 1, "R4 set bit 31");
    issue(0, 20'h00008, 2'd0, 0, 0, 1, "R4 readback after set");
    issue(1, 20'h08008, 2'd1, 32'h0000_0000, 0, 1, "R5 clear bit 0");
    issue(1, 20'h08008, 2'd1, 32'hFFFF_FFE8, 0, 1, "R5 clear bit 8 high bits junk");
    issue(0, 20'h00008, 2'd0, 0, 0, 0, "R5 readback after clear");

    issue(0, 20'h0400C, 2'd1, 32'hDEAD_BEEF, 0, 1, "R6 alias 01 plain write");
    issue(0, 20'h0C00C, 2'd0, 0, 0, 0, "R6 read via set alias");
    issue(1, 20'h0800C, 2'd0, 0, 0, 1, "R6 read via clear alias");

    issue(0, 20'h10004, 2'd2, 32'hABCD_EF01, 32'h0000_FF00, 1, "R7 masked update page1");
    issue(0, 20'h10004, 2'd0, 0, 0, 1, "R7 readback masked");
    issue(1, 20'h00008, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R7 masked on page0 refused");
    issue(1, 20'h00008, 2'd0, 0, 0, 1, "R7 page0 untouched");

    issue(0, 20'h00008, 2'd1, 32'h0, 0, 0, "R8 untrusted word write");
    issue(1, 20'h0C00C, 2'd1, 32'd2, 0, 0, "R8 untrusted set alias");
    issue(0, 20'h1000C, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R8 untrusted masked");
    issue(0, 20'h00008, 2'd0, 0, 0, 0, "R8 page0 reg2 unchanged");
    issue(0, 20'h0000C, 2'd0, 0, 0, 0, "R8 page0 reg3 unchanged");
    issue(1, 20'h1000C, 2'd0, 0, 0, 0, "R8 page1 reg3 unchanged");

    issue(0, 20'h00020, 2'd0, 0, 0, 1, "R10 page0 past end read");
    issue(1, 20'h10010, 2'd1, 32'h1, 0, 1, "R10 page1 past end write");
    issue(0, 20'h20000, 2'd0, 0, 0, 1, "R10 other page read");
    issue(0, 20'h00008, 2'd3, 32'h1, 0, 1, "R10 reserved op");
    issue(0, 20'h00008, 2'd0, 0, 0, 1, "R10 reg unchanged");

    // both ports at once on the same register
    fork
      issue(0, 20'h0C014, 2'd1, 32'd7, 0, 1, "R11 port0 set bit 7");
      issue(1, 20'h0C014, 2'd1, 32'd9, 0, 1, "R11 port1 set bit 9");
      begin
        #2;
        check(req_ready[0] == 1'b1, "R2 port0 ready", {31'd0, req_ready[0]}, 32'd1);
        check(req_ready[1] == 1'b0, "R2 port1 held back", {31'd0, req_ready[1]}, 32'd0);
      end
    join
    fork
      issue(0, 20'h08014, 2'd1, 32'd7, 0, 1, "R11 port0 clear bit 7");
      issue(1, 20'h0C014, 2'd1, 32'd1, 0, 1, "R11 port1 set bit 1");
    join
    issue(1, 20'h00014, 2'd0, 0, 0, 0, "R11 readback");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 every request answered", sb.size(), 32'd0);
    for (int i = 0; i < NA; i++)
      check(alive_regs[i*32 +: 32] == m_alive[i], "R3 page0 outputs",
            alive_regs[i*32 +: 32], m_alive[i]);
    for (int i = 0; i < NU; i++)
      check(upper_regs[i*32 +: 32] == m_upper[i], "R3 page1 outputs",
            upper_regs[i*32 +: 32], m_upper[i]);
    finish_run();
  end
endmodule